// File: doc/BRIEF.md
# I2C SCL Rate Generator with Clock Stretching

This block times each half-period of the serial clock for an I2C master. A sequencer asks it for one phase at a time: it pulses `load`, the generator copies the programmed reload value into a down-counter, and it answers with a one-cycle `tick` when the count reaches zero. After the tick the counter stays idle until the next request. The reload value is chosen by software as (Fcy/Fscl − Fcy/1,111,111) − 1, where Fcy is the clock of this block and Fscl is the wanted bus rate. Common targets are 100 kHz and 400 kHz, and any rate up to 1 MHz is supported.

The generator also watches the real SCL wire through a synchroniser. When the master lets SCL float high, another device may still hold the line low. In that case the generator does not count. Counting starts from a fresh full reload only once the line is seen high. So each high phase lasts at least one full count, however long a slave or a competing master stretches the clock. Reload values of 0 and 1 are not legal settings. They are raised to 2 inside the block so that the counter can neither stall nor run freely.

Top module: `scl_rate_gen`

## Requirements
- R1: Out of reset, `tick` is 0 and `busy` is 0.
- R2: If `load` is captured while `scl_released` is 0, `tick` goes high for exactly one cycle, N clock edges after the capturing edge. N is the effective reload value.
- R3: After the rollover tick the counter stops. `busy` drops to 0 and no further `tick` occurs until the next `load`.
- R4: A `reload_val` of 0 or 1 acts as an effective reload of 2. Any value of 2 or more is used as it is.
- R5: While `scl_released` is 1 and the synchronised SCL is low, the counter is suspended. No `tick` is produced and `busy` stays 1.
- R6: SCL passes through a two-flop synchroniser. When the suspended generator first sees the synchronised line high, it reloads the full value N. Suppose `scl_in` rises just before edge E. Then `tick` follows N edges after edge E+2.
- R7: If the line is pulled low in the middle of a count while `scl_released` is 1, counting freezes. When the line is high again, the count restarts from the full N and does not resume from the frozen value.
- R8: A `load` that arrives while a count is running restarts the count. Only the last `load` produces a `tick`.
- R9: `tick` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (Fcy) |
| rst_n | input | 1 | Asynchronous reset, active low |
| reload_val | input | CNT_W | Programmed reload value for one SCL phase |
| load | input | 1 | Sequencer request to start a phase |
| scl_released | input | 1 | 1 while the master lets SCL float high |
| scl_in | input | 1 | Raw level sampled from the SCL wire |
| tick | output | 1 | One-cycle rollover pulse that ends a phase |
| busy | output | 1 | Counter running or suspended |

## Verification
The bench builds the generator with an 8-bit reload field and the default two-stage synchroniser. This keeps the full-scale reload of 255 within a short run, next to the clamped values 0 and 1. With the two-stage synchroniser, the exact delay from a wire edge to the reload can be predicted. A queue of expected tick cycles covers several cases:
- plain counts,
- restarts during a count,
- indefinite stretching,
- a line pulled low in the middle of a count.

The queue also catches any tick that should not have occurred.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } gen_state_e;

    localparam int unsigned MIN_RELOAD = 2;

endpackage

// File: rtl/scl_rate_sync.sv
module scl_rate_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/scl_rate_clamp.sv
module scl_rate_clamp #(
    parameter int unsigned CNT_W = 12
) (
    input  logic [CNT_W-1:0] raw_val,
    output logic [CNT_W-1:0] eff_val
);

    import scl_rate_pkg::*;

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);

    always_comb begin
        if (raw_val < FLOOR) begin
            eff_val = FLOOR;
        end else begin
            eff_val = raw_val;
        end
    end

endmodule

// File: rtl/scl_rate_core.sv
module scl_rate_core #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] eff_val,
    input  logic             load,
    input  logic             scl_released,
    input  logic             scl_hi,
    output logic             tick,
    output logic             busy
);

    import scl_rate_pkg::*;

    typedef struct packed {
        gen_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } core_reg_t;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    core_reg_t cur_d;
    core_reg_t cur_q;
    logic      stretched;

    assign stretched = scl_released && !scl_hi;

    always_comb begin
        cur_d      = cur_q;
        cur_d.tick = 1'b0;
        if (load) begin
            if (stretched) begin
                cur_d.st = ST_HOLD;
            end else begin
                cur_d.st  = ST_COUNT;
                cur_d.cnt = eff_val;
            end
        end else begin
            case (cur_q.st)
                ST_HOLD: begin
                    if (scl_hi) begin
                        cur_d.st  = ST_COUNT;
                        cur_d.cnt = eff_val;
                    end
                end
                ST_COUNT: begin
                    if (stretched) begin
                        cur_d.st = ST_HOLD;
                    end else begin
                        cur_d.cnt = cur_q.cnt - CNT_ONE;
                        if (cur_q.cnt == CNT_ONE) begin
                            cur_d.st   = ST_IDLE;
                            cur_d.tick = 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, cnt: '0, tick: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign tick = cur_q.tick;
    assign busy = (cur_q.st != ST_IDLE);

    // R9: rollover pulse lasts one cycle
    assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.tick |=> !cur_q.tick);

    // R3: counter stops after rollover unless a new request comes
    assert_stop_after_roll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.tick && !load) |=> (cur_q.st == ST_IDLE));

    // R5: suspended counter keeps its value while the line is low
    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_HOLD && !scl_hi && !load) |=> $stable(cur_q.cnt));

    // R4: an accepted request never starts below the floor
    assert_start_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !stretched) |=> (cur_q.cnt >= CNT_W'(MIN_RELOAD)));

    // R2: a tick follows only a count that was running
    assert_tick_from_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.tick) |-> (cur_q.cnt == '0 && $past(cur_q.st) == ST_COUNT));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             load,
    input  logic             scl_released,
    input  logic             scl_in,
    output logic             tick,
    output logic             busy
);

    logic             scl_hi;
    logic [CNT_W-1:0] eff_val;

    scl_rate_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (scl_in),
        .sync_out (scl_hi)
    );

    scl_rate_clamp #(
        .CNT_W (CNT_W)
    ) u_clamp (
        .raw_val (reload_val),
        .eff_val (eff_val)
    );

    scl_rate_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .eff_val      (eff_val),
        .load         (load),
        .scl_released (scl_released),
        .scl_hi       (scl_hi),
        .tick         (tick),
        .busy         (busy)
    );

endmodule

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] reload_val = '0;
    logic          load = 1'b0;
    logic          scl_released = 1'b0;
    logic          scl_in = 1'b1;
    logic          tick;
    logic          busy;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int exp_q[$];
    logic tick_prev = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    scl_rate_gen #(.CNT_W(CW), .SYNC_STAGES(2)) u_scl_rate_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_val   (reload_val),
        .load         (load),
        .scl_released (scl_released),
        .scl_in       (scl_in),
        .tick         (tick),
        .busy         (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected tick cycles and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (tick && tick_prev) chk(1'b0, "R9 tick twice in a row", 1, 0);
            if (tick) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected tick at cycle", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc == e, "R2 tick cycle", cyc, e);
                end
            end
            tick_prev <= tick;
        end
    end

    // driver: request a phase; expected tick N edges after the capture edge
    task automatic do_load(input int n_eff, input bit push);
        @(negedge clk);
        load = 1'b1;
        if (push) exp_q.push_back(cyc + 1 + n_eff);
        @(negedge clk);
        load = 1'b0;
    endtask

    // driver: line goes high; two sync stages plus the core edge
    task automatic line_high(input int n_eff);
        @(negedge clk);
        scl_in = 1'b1;
        exp_q.push_back(cyc + 3 + n_eff);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tick == 1'b0, "R1 tick in reset", tick, 0);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tick == 1'b0, "R1 tick after reset", tick, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);

        // R2: plain count, master driving low
        reload_val = 8'd10;
        do_load(10, 1'b1);
        chk(busy == 1'b1, "R2 busy while counting", busy, 1);
        drain();
        // R3: stopped after rollover
        repeat (30) @(negedge clk);
        chk(busy == 1'b0, "R3 idle after rollover", busy, 0);
        chk(exp_q.size() == 0, "R3 queue empty", exp_q.size(), 0);

        // R4: clamp of illegal values, and full scale
        reload_val = 8'd0;
        do_load(2, 1'b1);
        drain();
        reload_val = 8'd1;
        do_load(2, 1'b1);
        drain();
        reload_val = 8'd2;
        do_load(2, 1'b1);
        drain();
        reload_val = 8'd255;
        do_load(255, 1'b1);
        drain();

        // R8: restart during a count
        reload_val = 8'd10;
        do_load(10, 1'b0);
        repeat (3) @(negedge clk);
        do_load(10, 1'b1);
        drain();

        // R5 / R6: released but held low by another device
        reload_val = 8'd12;
        @(negedge clk);
        scl_released = 1'b1;
        scl_in = 1'b0;
        repeat (4) @(negedge clk);
        do_load(12, 1'b0);
        repeat (40) @(negedge clk);
        chk(busy == 1'b1, "R5 busy while stretched", busy, 1);
        chk(tick == 1'b0, "R5 no tick while stretched", tick, 0);
        line_high(12);
        drain();
        chk(busy == 1'b0, "R6 idle after stretched phase", busy, 0);

        // R6: released with the line already high counts at once
        do_load(12, 1'b1);
        drain();

        // R7: line pulled low in the middle of a count
        reload_val = 8'd10;
        do_load(10, 1'b0);
        repeat (2) @(negedge clk);
        scl_in = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy == 1'b1, "R7 frozen mid count", busy, 1);
        line_high(10);
        drain();
        chk(busy == 1'b0, "R7 idle after full reload", busy, 0);

        scl_released = 1'b0;
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R3 no pending ticks", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule